// File: doc/BRIEF.md
# Compare-Match Timer with Waveform Output

This block is an up-counting timer/counter with one compare channel and an output pin. The counter advances on each cycle where the timer tick enable is high. It runs in one of two modes. In free-running mode it wraps from its maximum value back to zero. In clear-on-compare mode a compare register sets the top of the count, so it also sets the period. On a compare match the output pin is toggled, cleared, set or left alone, as selected by a stored 2-bit action field.

Two flags serve an interrupt controller. A sticky overflow flag behaves like an extra count bit. A compare-match flag is raised on each match. Each flag has its own clear input, which models the interrupt acknowledge. Software can overwrite the counter at any time. A force strobe applies the selected action to the pin at once, which also lets the pin be given a known level before its output enable is raised.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter, both flags and the stored pin state are zero, the mode is free-running (code 00), and the compare value and action field are zero.
- R2: In free-running mode (any mode code other than 10) the counter adds one on each tick and wraps from all-ones to zero. It never clears early, and it holds its value while tick_i is low.
- R3: ovf_o rises on the same clock edge at which a tick takes the counter from all-ones to zero. It stays high until ovf_clr_i is pulsed. If a wrap and ovf_clr_i occur in the same cycle, the set wins.
- R4: In clear-on-compare mode (mode code 10), a tick while the counter equals the compare value returns the counter to zero. The count period is therefore the compare value plus one.
- R5: On a compare match (a tick while the counter equals the compare value), the pin state is updated by the action field: 00 leaves it unchanged, 01 toggles it, 10 clears it and 11 sets it.
- R6: Writing the action field does not change the pin state. The new value is applied from the first compare match after the write.
- R7: A force_i pulse applies the current action field to the pin state in the next cycle, without a match. It sets no compare flag and leaves the counter unchanged.
- R8: oc_o shows the stored pin state only while oc_en_i is high, and is 0 otherwise. The stored state can be changed while the output is disabled.
- R9: A counter write in the same cycle as a tick takes priority over the increment or clear. It also suppresses the compare match and the overflow for that tick.
- R10: cmf_o rises on the edge after a compare match and stays high until cmf_clr_i is pulsed. If a match and cmf_clr_i occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick enable |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | WIDTH | Counter write value |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_wdata_i | input | WIDTH | Compare register write value |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 2 | Mode code: 10 is clear-on-compare, any other code is free-running |
| act_we_i | input | 1 | Action field write strobe |
| act_wdata_i | input | 2 | Action code: 00 none, 01 toggle, 10 clear, 11 set |
| force_i | input | 1 | Force-compare strobe |
| ovf_clr_i | input | 1 | Overflow flag clear |
| cmf_clr_i | input | 1 | Compare flag clear |
| oc_en_i | input | 1 | Output pin enable |
| cnt_o | output | WIDTH | Current counter value |
| oc_o | output | 1 | Output pin value |
| ovf_o | output | 1 | Overflow flag |
| cmf_o | output | 1 | Compare-match flag |

## Verification
The bench builds the block with WIDTH = 4, so a full wrap takes only sixteen ticks. This allows an exhaustive sweep of every start value in free-running mode, with the expected count and overflow computed modulo sixteen. It also allows a sweep of every compare value in clear-on-compare mode, checked on every tick over more than two periods. The small width also keeps toggle runs short enough to check the pin over several match periods, as well as the priority of a counter write at the exact cycle where a wrap or match would otherwise happen.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  localparam logic [1:0] MODE_FREE = 2'b00;
  localparam logic [1:0] MODE_CTC  = 2'b10;

  function automatic logic apply_act(act_e act, logic cur);
    case (act)
      ACT_TOGGLE: return ~cur;
      ACT_CLEAR:  return 1'b0;
      ACT_SET:    return 1'b1;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/cmp_timer_count.sv
module cmp_timer_count
  import cmp_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic [WIDTH-1:0] cnt_wdata_i,
  input  logic             cmp_we_i,
  input  logic [WIDTH-1:0] cmp_wdata_i,
  input  logic             mode_we_i,
  input  logic [1:0]       mode_wdata_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             match_o,
  output logic             wrap_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q, cmp_q;
  logic [1:0]       mode_q;
  logic             adv, eq, ctc;

  assign adv = tick_i & ~cnt_we_i;   // a write blocks this tick
  assign eq  = (cnt_q == cmp_q);
  assign ctc = (mode_q == MODE_CTC);

  assign match_o = adv & eq;
  assign wrap_o  = adv & (cnt_q == CNT_MAX);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      mode_q <= MODE_FREE;
    end else begin
      if (cmp_we_i)  cmp_q  <= cmp_wdata_i;
      if (mode_we_i) mode_q <= mode_wdata_i;
      if (cnt_we_i)                cnt_q <= cnt_wdata_i;
      else if (tick_i && ctc && eq) cnt_q <= '0;
      else if (tick_i)              cnt_q <= cnt_q + 1'b1;
    end
  end

  p_wr_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_q == $past(cnt_wdata_i));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !cnt_we_i |=> $stable(cnt_q));
  p_free_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !cnt_we_i && !ctc |=> cnt_q == $past(cnt_q) + 1'b1);
  p_ctc_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !cnt_we_i && ctc && eq |=> cnt_q == '0);
endmodule

// File: rtl/cmp_timer_wave.sv
module cmp_timer_wave
  import cmp_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       match_i,
  input  logic       wrap_i,
  input  logic       force_i,
  input  logic       act_we_i,
  input  logic [1:0] act_wdata_i,
  input  logic       ovf_clr_i,
  input  logic       cmf_clr_i,
  input  logic       oc_en_i,
  output logic       oc_o,
  output logic       ovf_o,
  output logic       cmf_o
);
  act_e act_q;
  logic oc_q, ovf_q, cmf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= ACT_NONE;
      oc_q  <= 1'b0;
      ovf_q <= 1'b0;
      cmf_q <= 1'b0;
    end else begin
      if (act_we_i) act_q <= act_e'(act_wdata_i);
      // match and force use the field held before this edge
      if (match_i || force_i) oc_q <= apply_act(act_q, oc_q);
      if (wrap_i)         ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
      if (match_i)        cmf_q <= 1'b1;
      else if (cmf_clr_i) cmf_q <= 1'b0;
    end
  end

  assign oc_o  = oc_en_i & oc_q;
  assign ovf_o = ovf_q;
  assign cmf_o = cmf_q;

  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !ovf_clr_i |=> ovf_q);
  p_ovf_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> ovf_q);
  p_cmf_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> cmf_q);
  p_force_no_cmf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i && !match_i && !cmf_q |=> !cmf_q);
  p_act_none_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q == ACT_NONE && !act_we_i |=> $stable(oc_q));
  p_no_event_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_i && !force_i |=> $stable(oc_q));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic [WIDTH-1:0] cnt_wdata_i,
  input  logic             cmp_we_i,
  input  logic [WIDTH-1:0] cmp_wdata_i,
  input  logic             mode_we_i,
  input  logic [1:0]       mode_wdata_i,
  input  logic             act_we_i,
  input  logic [1:0]       act_wdata_i,
  input  logic             force_i,
  input  logic             ovf_clr_i,
  input  logic             cmf_clr_i,
  input  logic             oc_en_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             oc_o,
  output logic             ovf_o,
  output logic             cmf_o
);
  logic match, wrap;

  cmp_timer_count #(.WIDTH(WIDTH)) u_count (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .cnt_we_i     (cnt_we_i),
    .cnt_wdata_i  (cnt_wdata_i),
    .cmp_we_i     (cmp_we_i),
    .cmp_wdata_i  (cmp_wdata_i),
    .mode_we_i    (mode_we_i),
    .mode_wdata_i (mode_wdata_i),
    .cnt_o        (cnt_o),
    .match_o      (match),
    .wrap_o       (wrap)
  );

  cmp_timer_wave u_wave (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .match_i     (match),
    .wrap_i      (wrap),
    .force_i     (force_i),
    .act_we_i    (act_we_i),
    .act_wdata_i (act_wdata_i),
    .ovf_clr_i   (ovf_clr_i),
    .cmf_clr_i   (cmf_clr_i),
    .oc_en_i     (oc_en_i),
    .oc_o        (oc_o),
    .ovf_o       (ovf_o),
    .cmf_o       (cmf_o)
  );

  p_oc_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oc_en_i |-> !oc_o);
endmodule

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tick_i = 0, cnt_we_i = 0, cmp_we_i = 0, mode_we_i = 0, act_we_i = 0;
  logic force_i = 0, ovf_clr_i = 0, cmf_clr_i = 0, oc_en_i = 1;
  logic [W-1:0] cnt_wdata_i = '0, cmp_wdata_i = '0;
  logic [1:0] mode_wdata_i = '0, act_wdata_i = '0;
  logic [W-1:0] cnt_o;
  logic oc_o, ovf_o, cmf_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  cmp_timer #(.WIDTH(W)) u_cmp_timer (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask
  task automatic wr_cnt(int v);
    cnt_we_i = 1; cnt_wdata_i = W'(v); cyc(); cnt_we_i = 0;
  endtask
  task automatic wr_cmp(int v);
    cmp_we_i = 1; cmp_wdata_i = W'(v); cyc(); cmp_we_i = 0;
  endtask
  task automatic wr_mode(int v);
    mode_we_i = 1; mode_wdata_i = 2'(v); cyc(); mode_we_i = 0;
  endtask
  task automatic wr_act(int v);
    act_we_i = 1; act_wdata_i = 2'(v); cyc(); act_we_i = 0;
  endtask
  task automatic ticks(int n);
    tick_i = 1; repeat (n) cyc(); tick_i = 0;
  endtask
  task automatic do_force();
    force_i = 1; cyc(); force_i = 0;
  endtask
  task automatic clr_ovf();
    ovf_clr_i = 1; cyc(); ovf_clr_i = 0;
  endtask
  task automatic clr_cmf();
    cmf_clr_i = 1; cyc(); cmf_clr_i = 0;
  endtask

  initial begin
    int oc_keep;
    repeat (3) cyc();
    rst_ni = 1; cyc();
    // R1 reset state
    chk("R1 cnt", cnt_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 cmf", cmf_o, 0);
    chk("R1 oc", oc_o, 0);

    // R2 / R3: free-running sweep over every start value
    wr_mode(0);
    for (int s = 0; s < M; s++) begin
      for (int k = 0; k < 3; k++) begin
        int n;
        n = (k == 0) ? 1 : (k == 1) ? 7 : M + 3;
        wr_cnt(s); clr_ovf();
        ticks(n);
        chk("R2 free count", cnt_o, (s + n) % M);
        chk("R3 wrap flag", ovf_o, (s + n >= M) ? 1 : 0);
      end
    end
    wr_cnt(9); repeat (3) cyc();
    chk("R2 hold without tick", cnt_o, 9);
    wr_mode(1); wr_cmp(3); wr_cnt(3); ticks(1);
    chk("R2 code 01 is free-running", cnt_o, 4);
    wr_mode(0);

    // R3 overflow on the wrap edge, sticky, clear, set wins
    wr_cnt(M - 1); clr_ovf(); ticks(1);
    chk("R3 ovf at wrap", ovf_o, 1);
    chk("R3 cnt zero at wrap", cnt_o, 0);
    ticks(3);
    chk("R3 ovf sticky", ovf_o, 1);
    ovf_clr_i = 1; tick_i = 1; cyc(); ovf_clr_i = 0; tick_i = 0;
    chk("R3 ovf cleared", ovf_o, 0);
    wr_cnt(M - 1);
    ovf_clr_i = 1; tick_i = 1; cyc(); ovf_clr_i = 0; tick_i = 0;
    chk("R3 set beats clear", ovf_o, 1);

    // R4 clear-on-compare sweep over every compare value
    wr_mode(2);
    for (int c = 0; c < M; c++) begin
      wr_cmp(c); wr_cnt(0);
      tick_i = 1;
      for (int n = 1; n <= 2 * c + 3; n++) begin
        cyc();
        chk("R4 ctc count", cnt_o, n % (c + 1));
      end
      tick_i = 0;
    end

    // R10 compare flag
    wr_cmp(5); wr_cnt(4); clr_cmf(); ticks(1);
    chk("R10 no flag before match", cmf_o, 0);
    ticks(1);
    chk("R10 flag after match", cmf_o, 1);
    chk("R4 cleared at match", cnt_o, 0);
    clr_cmf();
    chk("R10 flag cleared", cmf_o, 0);
    wr_cnt(5);
    cmf_clr_i = 1; tick_i = 1; cyc(); cmf_clr_i = 0; tick_i = 0;
    chk("R10 set beats clear", cmf_o, 1);

    // R5 actions
    wr_cmp(3);
    wr_act(3); wr_cnt(3); ticks(1);
    chk("R5 set", oc_o, 1);
    wr_act(2); wr_cnt(3); ticks(1);
    chk("R5 clear", oc_o, 0);
    wr_act(1); wr_cnt(0);
    tick_i = 1;
    for (int n = 1; n <= 12; n++) begin
      cyc();
      chk("R5 toggle", oc_o, (n / 4) % 2);
    end
    tick_i = 0;
    wr_act(0); wr_cnt(3); ticks(1);
    chk("R5 none", oc_o, 1);

    // R6 new action applies only from next match
    wr_act(2);
    chk("R6 write no effect", oc_o, 1);
    wr_cnt(0); ticks(3);
    chk("R6 held before match", oc_o, 1);
    ticks(1);
    chk("R6 applied at match", oc_o, 0);

    // R7 force
    wr_act(3); clr_cmf(); wr_cnt(2);
    do_force();
    chk("R7 force set", oc_o, 1);
    chk("R7 no cmf", cmf_o, 0);
    chk("R7 cnt unchanged", cnt_o, 2);
    wr_act(1); do_force();
    chk("R7 force toggle", oc_o, 0);

    // R8 enable gating and init while disabled
    oc_en_i = 0; wr_act(3); do_force();
    chk("R8 disabled output low", oc_o, 0);
    oc_en_i = 1; #1;
    chk("R8 enabled shows state", oc_o, 1);

    // R9 write beats tick and blocks match / overflow
    wr_act(1); wr_cnt(3); clr_cmf();
    oc_keep = oc_o;
    cnt_we_i = 1; cnt_wdata_i = 3; tick_i = 1; cyc(); cnt_we_i = 0; tick_i = 0;
    chk("R9 cnt from write", cnt_o, 3);
    chk("R9 no cmf", cmf_o, 0);
    chk("R9 no action", oc_o, oc_keep);
    wr_mode(0); wr_cnt(M - 1); clr_ovf();
    cnt_we_i = 1; cnt_wdata_i = W'(M - 1); tick_i = 1; cyc(); cnt_we_i = 0; tick_i = 0;
    chk("R9 no overflow", ovf_o, 0);
    chk("R9 cnt held by write", cnt_o, M - 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule